// File: doc/BRIEF.md
# Masked-Compare Repetitive Interrupt Timer

This block raises a periodic interrupt from a free-running up-counter. On every cycle the counter is compared against a programmable compare value. A per-bit mask removes any chosen bit positions from that comparison. A masked low-order field therefore gives a burst of consecutive matches. A masked high-order field gives a match that repeats each time the unmasked low bits come round again. Neither case needs software to reload the compare value.

A small word-wide register port gives access to four registers: compare, mask, control/status and counter. Reads are combinational. The control word enables counting, selects clear-on-match and selects whether the debug-halt input may freeze the counter. The control word also holds the sticky interrupt flag, which drives the interrupt output.

With clear-on-match set, the counter returns to zero on the clock after a match. The interval is then a fixed compare+1 counts. With clear-on-match off, the counter wraps through its full range.

Top module: `rep_irq_timer`

## Requirements
- R1: After reset the compare, mask, control and counter registers all read 0 and `irq` is low.
- R2: The register at `bus_addr` 0 is the compare value and the one at 1 is the mask. At 2 is control/status: bit0 enables counting, bit1 selects clear-on-match, bit2 selects halt-on-debug and bit3 is the interrupt flag. At 3 is the counter. `bus_rdata` shows the addressed register combinationally. A write with `bus_wr` high takes effect at the next clock edge.
- R3: A match is declared when `(counter & ~mask) == (compare & ~mask)`. A mask bit of 1 removes that bit position from the comparison.
- R4: Counting is active when bit0 is 1 and bit2 and `dbg_halt` are not both 1. While counting is active, the counter increases by one per clock. Otherwise the counter holds its value.
- R5: A match seen on a clock edge while counting is active sets the interrupt flag at that edge. `irq` then follows the flag. A match while counting is inactive sets nothing.
- R6: The flag is sticky. Writing control with bit3 = 1 clears it, and writing bit3 = 0 leaves it unchanged. If a new flagged match occurs at the same edge as the clearing write, the flag ends set.
- R7: When clear-on-match is set and a match occurs while counting is active, the counter is 0 after that edge. The repeat interval is then compare+1 clocks.
- R8: When bit2 is 0, `dbg_halt` has no effect on counting.
- R9: A write to the counter loads the written value at the next edge. It overrides both the increment and clear-on-match in that cycle.
- R10: With clear-on-match off, the counter wraps from 0xFFFFFFFF to 0 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| dbg_halt | input | 1 | Debug-halt request |
| irq | output | 1 | Interrupt request (sticky flag) |

## Verification
Read data appears in the same cycle as the address. A written value, a counter increment, a clear-on-match and a flag set or clear all become visible one clock after the edge at which they are sampled. The bench drives inputs on the falling edge. Its behavioural model advances at the rising edge from the same inputs. `irq` and the read data are compared against the model at the next falling edge. Every result is therefore checked in the exact cycle it is due, including a flag clear and a new match landing on one edge, and a counter write coinciding with clear-on-match.

// File: rtl/rep_irq_timer.sv
module rep_irq_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         dbg_halt,
  output logic         irq
);
  localparam logic [1:0] A_CMP = 2'd0, A_MASK = 2'd1, A_CTRL = 2'd2, A_CNT = 2'd3;
  localparam int B_EN = 0, B_COM = 1, B_HALT = 2, B_FLAG = 3;

  logic [W-1:0] cmp_q, mask_q, cnt_q;
  logic         en_q, com_q, halt_q, flag_q;

  wire run    = en_q && !(halt_q && dbg_halt);
  wire hit    = ((cnt_q ^ cmp_q) & ~mask_q) == '0;
  wire wr_cmp = bus_wr && bus_addr == A_CMP;
  wire wr_msk = bus_wr && bus_addr == A_MASK;
  wire wr_ctl = bus_wr && bus_addr == A_CTRL;
  wire wr_cnt = bus_wr && bus_addr == A_CNT;
  wire fire   = run && hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_q <= '0; mask_q <= '0; cnt_q <= '0;
      en_q <= 1'b0; com_q <= 1'b0; halt_q <= 1'b0; flag_q <= 1'b0;
    end else begin
      if (wr_cmp) cmp_q <= bus_wdata;
      if (wr_msk) mask_q <= bus_wdata;
      if (wr_ctl) begin
        en_q   <= bus_wdata[B_EN];
        com_q  <= bus_wdata[B_COM];
        halt_q <= bus_wdata[B_HALT];
      end
      if (wr_cnt)              cnt_q <= bus_wdata;
      else if (fire && com_q)  cnt_q <= '0;
      else if (run)            cnt_q <= cnt_q + 1'b1;
      if (fire)                            flag_q <= 1'b1;
      else if (wr_ctl && bus_wdata[B_FLAG]) flag_q <= 1'b0;
    end

  always_comb
    case (bus_addr)
      A_CMP:   bus_rdata = cmp_q;
      A_MASK:  bus_rdata = mask_q;
      A_CTRL:  bus_rdata = {{(W-4){1'b0}}, flag_q, halt_q, com_q, en_q};
      default: bus_rdata = cnt_q;
    endcase

  assign irq = flag_q;

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q));
  a_r5_match_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hit) |=> irq);
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(run && hit)) |=> !irq);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_ctl && bus_wdata[B_FLAG])) |=> irq);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[B_FLAG] && !(run && hit)) |=> !irq);
  a_r7_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hit && com_q && !wr_cnt) |=> cnt_q == '0);
  a_r9_counter_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(bus_wdata));
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_cnt && cnt_q == '1 && !(hit && com_q)) |=> cnt_q == '0);
endmodule

// File: tb/rep_irq_timer_tb.sv
`timescale 1ns/1ps
module rep_irq_timer_tb;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, dbg_halt = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  rep_irq_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [31:0] m_cmp = 0, m_mask = 0, m_cnt = 0;
  bit m_en = 0, m_com = 0, m_halt = 0, m_flag = 0;

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cmp;
      2'd1: return m_mask;
      2'd2: return {28'd0, m_flag, m_halt, m_com, m_en};
      default: return m_cnt;
    endcase
  endfunction

  task automatic check_outputs();
    logic [31:0] exp_rd;
    exp_rd = m_read(bus_addr);
    checks++;
    if (irq !== m_flag) begin
      fails++;
      $display("FAIL %s irq actual %0b expected %0b", cur_req, irq, m_flag);
    end
    checks++;
    if (bus_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s rdata[%0d] actual %h expected %h", cur_req, bus_addr, bus_rdata, exp_rd);
    end
  endtask

  task automatic step();
    bit active, match;
    logic [31:0] nxt;
    @(posedge clk);
    active = m_en && !(m_halt && dbg_halt);
    match  = ((m_cnt & ~m_mask) == (m_cmp & ~m_mask));
    if (bus_wr && bus_addr == 2'd3) nxt = bus_wdata;
    else if (active && match && m_com) nxt = 0;
    else if (active) nxt = m_cnt + 1;
    else nxt = m_cnt;
    if (active && match) m_flag = 1;
    else if (bus_wr && bus_addr == 2'd2 && bus_wdata[3]) m_flag = 0;
    if (bus_wr && bus_addr == 2'd2) begin
      m_en = bus_wdata[0]; m_com = bus_wdata[1]; m_halt = bus_wdata[2];
    end
    if (bus_wr && bus_addr == 2'd0) m_cmp = bus_wdata;
    if (bus_wr && bus_addr == 2'd1) m_mask = bus_wdata;
    m_cnt = nxt;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    bus_wr = 0; bus_addr = a;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  initial begin
    #25 rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin bus_addr = a[1:0]; #1 check_outputs(); end

    cur_req = "R2";
    wr(0, 32'd10); wr(1, 32'h0); idle(1, 0); idle(1, 1);
    cur_req = "R4";
    idle(3, 3);
    cur_req = "R5";
    wr(2, 32'h1); idle(15, 3); idle(2, 2);
    cur_req = "R6";
    wr(2, 32'h1); idle(2, 2); wr(2, 32'h9); idle(3, 2);

    cur_req = "R5";
    wr(2, 32'h8); wr(3, 32'd20); wr(0, 32'd20); idle(4, 2);

    cur_req = "R6";
    wr(2, 32'h1); wr(3, 32'd19); idle(1, 2); wr(2, 32'h9); idle(3, 2);

    cur_req = "R7";
    wr(0, 32'd5); wr(3, 32'd0); wr(2, 32'h3);
    for (int k = 0; k < 5; k++) begin idle(3, 3); wr(2, 32'hB); idle(2, 3); end

    cur_req = "R9";
    wr(0, 32'd8); idle(6, 3); wr(3, 32'd8); idle(3, 3); wr(3, 32'd100); idle(2, 3);

    cur_req = "R3";
    wr(2, 32'h9); wr(1, 32'h0000000F); wr(0, 32'h30); wr(3, 32'h2A); idle(10, 2);
    wr(2, 32'h9); idle(12, 3); wr(2, 32'h9); idle(4, 2);
    wr(1, 32'hFFFFFF00); wr(0, 32'h05); wr(3, 32'h1F0); idle(30, 3);
    wr(2, 32'h9); idle(240, 3); idle(2, 2);

    cur_req = "R4";
    wr(1, 32'h0); wr(0, 32'hFFFF0000); wr(2, 32'hD);
    dbg_halt = 1; idle(6, 3); dbg_halt = 0; idle(3, 3);
    cur_req = "R8";
    wr(2, 32'h1); dbg_halt = 1; idle(6, 3); dbg_halt = 0;

    cur_req = "R10";
    wr(3, 32'hFFFFFFF8); idle(14, 3); idle(1, 2);

    cur_req = "R7";
    wr(0, 32'h7FFFFFFF); wr(2, 32'h3); wr(3, 32'h7FFFFFFC); idle(10, 3);
    cur_req = "R9";
    wr(0, 32'd4); wr(3, 32'd3); idle(1, 3); wr(3, 32'd50); idle(2, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog %s run did not complete", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule